// File: doc/BRIEF.md
# Dual-Antenna Pilot Tone Inserter

This block sits in an OFDM transmit chain ahead of the inverse FFT. Frequency-domain samples for two antennas arrive as a stream, one subcarrier per valid cycle, 64 subcarriers per OFDM symbol in index order, with a last flag on the final subcarrier. The block counts the subcarrier index itself. Where the index matches one of the configured pilot positions, it replaces the data sample with a programmed pilot value. Every other subcarrier passes through untouched.

There are two pilot tones. Each is placed at a pair of subcarrier positions that mirror each other about DC, and each has its own signed Q1.15 value per antenna. An optional scrambling mode applies one pseudo-random sign to every pilot of a symbol, and that sign changes from symbol to symbol. A packet-start pulse restarts the sign sequence. In single-antenna mode only the chosen antenna carries signal. The output stream follows the input by exactly one cycle.

Top module: `ofdm_pilot_insert`

## Requirements
- R1: Every output appears one clock after its input. `out_valid` equals the previous cycle's `in_valid`, and `out_last` equals the previous cycle's `in_valid && in_last`.
- R2: The first valid sample after reset, or after a valid sample with `in_last` high, has subcarrier index 0. Each later valid sample adds one. A sample whose index matches no pilot position leaves on both antennas with its real and imaginary parts unchanged.
- R3: At either position of tone 0 (`cfg_t0_lo` or `cfg_t0_hi`), antenna A outputs real = `cfg_t0_a`, imaginary = 0, and antenna B outputs real = `cfg_t0_b`, imaginary = 0.
- R4: At either position of tone 1 (`cfg_t1_lo` or `cfg_t1_hi`), antenna A outputs `cfg_t1_a` and antenna B outputs `cfg_t1_b` as the real part, with the imaginary part 0.
- R5: If a subcarrier matches positions of both tones, tone 0 is used.
- R6: With `cfg_scramble` low, pilots keep their programmed sign. The sign generator still advances at every symbol end.
- R7: The sign generator is a 7-bit register s with polynomial x^7 + x^4 + 1. It starts at 7'h7F. At each valid sample with `in_last` high, s becomes {s[5:0], s[6]^s[3]}. With `cfg_scramble` high, every pilot of a symbol is negated when s[6] is 1 during that symbol.
- R8: Negating the most negative pilot value 16'h8000 gives 16'h7FFF.
- R9: A `pkt_start` pulse sets s back to 7'h7F for the next cycle. If the pulse coincides with a symbol-end step, the reload wins.
- R10: With `cfg_single` high, `cfg_single_b` selects the driven antenna (0 = A, 1 = B). The other antenna outputs zero on every subcarrier.
- R11: While `rst` is high, `out_valid` and `out_last` are 0, all output samples are 0, the subcarrier index returns to 0 and s returns to 7'h7F.
- R12: In a cycle after `in_valid` was low, all output samples are 0. An idle cycle does not advance the subcarrier index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_start | input | 1 | Reloads the sign generator |
| in_valid | input | 1 | Input sample valid |
| in_last | input | 1 | Last subcarrier of the symbol |
| in_a_re | input | 16 | Antenna A real part |
| in_a_im | input | 16 | Antenna A imaginary part |
| in_b_re | input | 16 | Antenna B real part |
| in_b_im | input | 16 | Antenna B imaginary part |
| cfg_t0_lo | input | 6 | Tone 0 first position |
| cfg_t0_hi | input | 6 | Tone 0 mirrored position |
| cfg_t1_lo | input | 6 | Tone 1 first position |
| cfg_t1_hi | input | 6 | Tone 1 mirrored position |
| cfg_t0_a | input | 16 | Tone 0 value, antenna A (Q1.15) |
| cfg_t0_b | input | 16 | Tone 0 value, antenna B (Q1.15) |
| cfg_t1_a | input | 16 | Tone 1 value, antenna A (Q1.15) |
| cfg_t1_b | input | 16 | Tone 1 value, antenna B (Q1.15) |
| cfg_scramble | input | 1 | Enable per-symbol pilot sign scrambling |
| cfg_single | input | 1 | Single-antenna mode |
| cfg_single_b | input | 1 | In single-antenna mode, drive antenna B |
| out_valid | output | 1 | Output sample valid |
| out_last | output | 1 | Last subcarrier of the output symbol |
| out_a_re | output | 16 | Antenna A real part |
| out_a_im | output | 16 | Antenna A imaginary part |
| out_b_re | output | 16 | Antenna B real part |
| out_b_im | output | 16 | Antenna B imaginary part |

## Verification
Two events can land in the same clock edge: the symbol-end step of the sign generator and a `pkt_start` reload. The bench first runs symbols until the step it is about to take would yield a clear sign bit. It then raises `pkt_start` on the last subcarrier of a symbol. The following scrambled symbol must carry negated pilots, which only a reload that overrode the step can produce. A second pairing, tone positions shared by both tones, is judged by the pilot value that appears at the shared subcarriers.

// File: rtl/pilot_pkg.sv
package pilot_pkg;
    localparam int NUM_SC    = 64;
    localparam int IDX_W     = $clog2(NUM_SC);
    localparam int SMP_W     = 16;
    localparam int NUM_TONES = 2;
    localparam int NUM_ANT   = 2;
    localparam int LFSR_W    = 7;
    localparam int LFSR_TAP  = 3;
    localparam logic [LFSR_W-1:0] LFSR_SEED = '1;

    typedef logic signed [SMP_W-1:0] smp_t;

    typedef struct packed {
        smp_t re;
        smp_t im;
    } cplx_t;

    typedef enum logic [1:0] {
        SRC_ZERO  = 2'd0,
        SRC_DATA  = 2'd1,
        SRC_PILOT = 2'd2
    } src_e;

    function automatic smp_t neg_sat(input smp_t v);
        smp_t most_neg;
        most_neg = {1'b1, {(SMP_W-1){1'b0}}};
        if (v == most_neg) return ~most_neg;
        return -v;
    endfunction
endpackage

// File: rtl/pilot_scrambler.sv
module pilot_scrambler
    import pilot_pkg::*;
#(
    parameter int W   = LFSR_W,
    parameter int TAP = LFSR_TAP,
    parameter logic [W-1:0] SEED = LFSR_SEED
) (
    input  logic clk,
    input  logic rst,
    input  logic reseed,
    input  logic step,
    output logic flip
);
    logic [W-1:0] state;

    always_ff @(posedge clk) begin
        if (rst || reseed)
            state <= SEED;
        else if (step)
            state <= {state[W-2:0], state[W-1] ^ state[TAP]};
    end

    assign flip = state[W-1];

    assert_lfsr_live_R7: assert property (@(posedge clk) disable iff (rst)
        state != '0);

    assert_reseed_wins_R9: assert property (@(posedge clk) disable iff (rst)
        reseed |=> state == SEED);
endmodule

// File: rtl/pilot_locator.sv
module pilot_locator
    import pilot_pkg::*;
#(
    parameter int NT = NUM_TONES,
    parameter int IW = IDX_W,
    localparam int TW = (NT > 1) ? $clog2(NT) : 1
) (
    input  logic [IW-1:0] idx,
    input  logic [IW-1:0] pos_lo [NT],
    input  logic [IW-1:0] pos_hi [NT],
    output logic          hit,
    output logic [TW-1:0] tone
);
    logic [NT-1:0] match;

    for (genvar t = 0; t < NT; t++) begin : g_cmp
        assign match[t] = (idx == pos_lo[t]) || (idx == pos_hi[t]);
    end

    // lowest tone number has priority
    always_comb begin
        hit  = |match;
        tone = '0;
        for (int t = NT - 1; t >= 0; t--)
            if (match[t]) tone = TW'(t);
    end
endmodule

// File: rtl/pilot_lane.sv
module pilot_lane
    import pilot_pkg::*;
#(
    parameter int NT = NUM_TONES,
    localparam int TW = (NT > 1) ? $clog2(NT) : 1
) (
    input  logic          valid,
    input  logic          drive,
    input  logic          hit,
    input  logic [TW-1:0] tone,
    input  logic          flip,
    input  cplx_t         din,
    input  smp_t          tval [NT],
    output cplx_t         dout
);
    src_e src;
    smp_t pv;

    always_comb begin
        pv = tval[tone];
        if (flip) pv = neg_sat(pv);
    end

    always_comb begin
        if (!valid || !drive) src = SRC_ZERO;
        else if (hit)         src = SRC_PILOT;
        else                  src = SRC_DATA;
    end

    always_comb begin
        unique case (src)
            SRC_DATA:  dout = din;
            SRC_PILOT: dout = '{re: pv, im: '0};
            default:   dout = '0;
        endcase
    end
endmodule

// File: rtl/ofdm_pilot_insert.sv
module ofdm_pilot_insert
    import pilot_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pkt_start,
    input  logic             in_valid,
    input  logic             in_last,
    input  logic [SMP_W-1:0] in_a_re,
    input  logic [SMP_W-1:0] in_a_im,
    input  logic [SMP_W-1:0] in_b_re,
    input  logic [SMP_W-1:0] in_b_im,
    input  logic [IDX_W-1:0] cfg_t0_lo,
    input  logic [IDX_W-1:0] cfg_t0_hi,
    input  logic [IDX_W-1:0] cfg_t1_lo,
    input  logic [IDX_W-1:0] cfg_t1_hi,
    input  logic [SMP_W-1:0] cfg_t0_a,
    input  logic [SMP_W-1:0] cfg_t0_b,
    input  logic [SMP_W-1:0] cfg_t1_a,
    input  logic [SMP_W-1:0] cfg_t1_b,
    input  logic             cfg_scramble,
    input  logic             cfg_single,
    input  logic             cfg_single_b,
    output logic             out_valid,
    output logic             out_last,
    output logic [SMP_W-1:0] out_a_re,
    output logic [SMP_W-1:0] out_a_im,
    output logic [SMP_W-1:0] out_b_re,
    output logic [SMP_W-1:0] out_b_im
);
    localparam int TW = (NUM_TONES > 1) ? $clog2(NUM_TONES) : 1;

    logic [IDX_W-1:0] sc_idx;
    logic [IDX_W-1:0] pos_lo [NUM_TONES];
    logic [IDX_W-1:0] pos_hi [NUM_TONES];
    smp_t             tval   [NUM_ANT][NUM_TONES];
    cplx_t            lane_in  [NUM_ANT];
    cplx_t            lane_out [NUM_ANT];
    cplx_t            lane_q   [NUM_ANT];
    logic [NUM_ANT-1:0] drive;
    logic             hit;
    logic [TW-1:0]    tone;
    logic             sign_bit;
    logic             flip_now;

    // subcarrier position within the symbol
    always_ff @(posedge clk) begin
        if (rst)
            sc_idx <= '0;
        else if (in_valid)
            sc_idx <= in_last ? '0 : sc_idx + 1'b1;
    end

    assign pos_lo[0] = cfg_t0_lo;
    assign pos_hi[0] = cfg_t0_hi;
    assign pos_lo[1] = cfg_t1_lo;
    assign pos_hi[1] = cfg_t1_hi;

    assign tval[0][0] = smp_t'(cfg_t0_a);
    assign tval[0][1] = smp_t'(cfg_t1_a);
    assign tval[1][0] = smp_t'(cfg_t0_b);
    assign tval[1][1] = smp_t'(cfg_t1_b);

    assign lane_in[0] = '{re: smp_t'(in_a_re), im: smp_t'(in_a_im)};
    assign lane_in[1] = '{re: smp_t'(in_b_re), im: smp_t'(in_b_im)};

    assign drive[0] = !cfg_single || !cfg_single_b;
    assign drive[1] = !cfg_single ||  cfg_single_b;

    pilot_locator #(.NT(NUM_TONES), .IW(IDX_W)) u_locator (
        .idx    (sc_idx),
        .pos_lo (pos_lo),
        .pos_hi (pos_hi),
        .hit    (hit),
        .tone   (tone)
    );

    pilot_scrambler u_scrambler (
        .clk    (clk),
        .rst    (rst),
        .reseed (pkt_start),
        .step   (in_valid && in_last),
        .flip   (sign_bit)
    );

    assign flip_now = cfg_scramble && sign_bit;

    for (genvar g = 0; g < NUM_ANT; g++) begin : g_lane
        pilot_lane #(.NT(NUM_TONES)) u_lane (
            .valid (in_valid),
            .drive (drive[g]),
            .hit   (hit),
            .tone  (tone),
            .flip  (flip_now),
            .din   (lane_in[g]),
            .tval  (tval[g]),
            .dout  (lane_out[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            for (int a = 0; a < NUM_ANT; a++) lane_q[a] <= '0;
        end else begin
            out_valid <= in_valid;
            out_last  <= in_valid && in_last;
            for (int a = 0; a < NUM_ANT; a++) lane_q[a] <= lane_out[a];
        end
    end

    assign out_a_re = lane_q[0].re;
    assign out_a_im = lane_q[0].im;
    assign out_b_re = lane_q[1].re;
    assign out_b_im = lane_q[1].im;

    assert_out_delay_R1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (out_valid == $past(in_valid)) &&
                 (out_last == $past(in_valid && in_last)));

    assert_idle_zero_R12: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (out_a_re == '0) && (out_a_im == '0) &&
                      (out_b_re == '0) && (out_b_im == '0));

    assert_single_a_off_R10: assert property (@(posedge clk) disable iff (rst)
        (cfg_single && cfg_single_b) |=> (out_a_re == '0) && (out_a_im == '0));

    assert_single_b_off_R10: assert property (@(posedge clk) disable iff (rst)
        (cfg_single && !cfg_single_b) |=> (out_b_re == '0) && (out_b_im == '0));
endmodule

// File: tb/test_ofdm_pilot_insert.sv
module test_ofdm_pilot_insert;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst, pkt_start, in_valid, in_last;
    logic [15:0] in_a_re, in_a_im, in_b_re, in_b_im;
    logic [5:0]  cfg_t0_lo, cfg_t0_hi, cfg_t1_lo, cfg_t1_hi;
    logic [15:0] cfg_t0_a, cfg_t0_b, cfg_t1_a, cfg_t1_b;
    logic        cfg_scramble, cfg_single, cfg_single_b;
    logic        out_valid, out_last;
    logic [15:0] out_a_re, out_a_im, out_b_re, out_b_im;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [6:0] m_lfsr;

    ofdm_pilot_insert i_ofdm_pilot_insert (
        .clk(clk), .rst(rst), .pkt_start(pkt_start),
        .in_valid(in_valid), .in_last(in_last),
        .in_a_re(in_a_re), .in_a_im(in_a_im), .in_b_re(in_b_re), .in_b_im(in_b_im),
        .cfg_t0_lo(cfg_t0_lo), .cfg_t0_hi(cfg_t0_hi),
        .cfg_t1_lo(cfg_t1_lo), .cfg_t1_hi(cfg_t1_hi),
        .cfg_t0_a(cfg_t0_a), .cfg_t0_b(cfg_t0_b),
        .cfg_t1_a(cfg_t1_a), .cfg_t1_b(cfg_t1_b),
        .cfg_scramble(cfg_scramble), .cfg_single(cfg_single), .cfg_single_b(cfg_single_b),
        .out_valid(out_valid), .out_last(out_last),
        .out_a_re(out_a_re), .out_a_im(out_a_im), .out_b_re(out_b_re), .out_b_im(out_b_im)
    );

    function automatic logic [15:0] m_neg(input logic [15:0] v);
        if (v == 16'h8000) return 16'h7FFF;
        return 16'(-v);
    endfunction

    function automatic logic [6:0] m_step(input logic [6:0] s);
        return {s[5:0], s[6] ^ s[3]};
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic m_expect(input int k, input bit ant,
                            input logic [15:0] dre, input logic [15:0] dim,
                            output logic [15:0] ere, output logic [15:0] eim);
        bit drv, h0, h1;
        logic [15:0] pv;
        drv = !cfg_single || (cfg_single_b == ant);
        h0 = (6'(k) == cfg_t0_lo) || (6'(k) == cfg_t0_hi);
        h1 = (6'(k) == cfg_t1_lo) || (6'(k) == cfg_t1_hi);
        pv = h0 ? (ant ? cfg_t0_b : cfg_t0_a) : (ant ? cfg_t1_b : cfg_t1_a);
        if (cfg_scramble && m_lfsr[6]) pv = m_neg(pv);
        if (!drv) begin
            ere = 16'h0; eim = 16'h0;
        end else if (h0 || h1) begin
            ere = pv; eim = 16'h0;
        end else begin
            ere = dre; eim = dim;
        end
    endtask

    task automatic drive_symbol(input string tag, input bit gaps, input bit start_at_last);
        logic [15:0] ear, eai, ebr, ebi;
        for (int k = 0; k < 64; k++) begin
            if (gaps && (k % 7 == 3)) begin
                @(negedge clk);
                in_valid = 1'b0; in_last = 1'b0;
                in_a_re = 16'h1234; in_a_im = 16'h5678; in_b_re = 16'h9ABC; in_b_im = 16'hDEF0;
                @(posedge clk); #1;
                chk("R12", "idle out_valid", 32'(out_valid), 32'd0);
                chk("R12", "idle samples", {out_a_re | out_a_im, out_b_re | out_b_im}, 32'd0);
            end
            @(negedge clk);
            in_valid  = 1'b1;
            in_last   = (k == 63);
            pkt_start = start_at_last && (k == 63);
            in_a_re = 16'(k * 257 + 3);
            in_a_im = 16'(k * 5 + 100);
            in_b_re = 16'(k * 1000 + 7);
            in_b_im = 16'(-(k * 3) - 1);
            m_expect(k, 1'b0, in_a_re, in_a_im, ear, eai);
            m_expect(k, 1'b1, in_b_re, in_b_im, ebr, ebi);
            @(posedge clk); #1;
            chk("R1", "out_valid", 32'(out_valid), 32'd1);
            chk("R1", "out_last", 32'(out_last), 32'(k == 63));
            chk(tag, $sformatf("sc %0d ant A", k), {out_a_re, out_a_im}, {ear, eai});
            chk(tag, $sformatf("sc %0d ant B", k), {out_b_re, out_b_im}, {ebr, ebi});
            if (k == 63) m_lfsr = start_at_last ? 7'h7F : m_step(m_lfsr);
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0; pkt_start = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); pkt_start = 1'b1;
        @(negedge clk); pkt_start = 1'b0;
        m_lfsr = 7'h7F;
    endtask

    task automatic t_reset();
        rst = 1'b1; pkt_start = 1'b0; in_valid = 1'b1; in_last = 1'b0;
        in_a_re = 16'h1111; in_a_im = 16'h2222; in_b_re = 16'h3333; in_b_im = 16'h4444;
        cfg_t0_lo = 6'd7;  cfg_t0_hi = 6'd57;
        cfg_t1_lo = 6'd21; cfg_t1_hi = 6'd43;
        cfg_t0_a = 16'h4000; cfg_t0_b = 16'hC000;
        cfg_t1_a = 16'h2000; cfg_t1_b = 16'h6000;
        cfg_scramble = 1'b0; cfg_single = 1'b0; cfg_single_b = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R11", "reset out_valid", 32'(out_valid), 32'd0);
        chk("R11", "reset out_last", 32'(out_last), 32'd0);
        chk("R11", "reset samples", {out_a_re | out_a_im, out_b_re | out_b_im}, 32'd0);
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;
        m_lfsr = 7'h7F;
    endtask

    task automatic t_basic();
        cfg_scramble = 1'b0;
        drive_symbol("R2 R3 R4", 1'b0, 1'b0);
        drive_symbol("R2 R3 R4 second symbol", 1'b0, 1'b0);
    endtask

    task automatic t_scramble();
        cfg_scramble = 1'b0;
        drive_symbol("R6", 1'b0, 1'b0);
        cfg_scramble = 1'b1;
        for (int s = 0; s < 8; s++) drive_symbol("R7", 1'b0, 1'b0);
        cfg_scramble = 1'b0;
    endtask

    task automatic t_most_negative();
        cfg_t0_a = 16'h8000; cfg_t1_b = 16'h8000;
        cfg_scramble = 1'b1;
        pulse_start();
        drive_symbol("R8 R9", 1'b0, 1'b0);
        cfg_t0_a = 16'h4000; cfg_t1_b = 16'h6000;
        cfg_scramble = 1'b0;
    endtask

    task automatic t_overlap();
        cfg_t1_lo = 6'd7; cfg_t1_hi = 6'd57;
        drive_symbol("R5", 1'b0, 1'b0);
        cfg_t1_lo = 6'd21; cfg_t1_hi = 6'd43;
    endtask

    task automatic t_single();
        cfg_single = 1'b1; cfg_single_b = 1'b0;
        drive_symbol("R10 antenna A", 1'b0, 1'b0);
        cfg_single_b = 1'b1;
        drive_symbol("R10 antenna B", 1'b0, 1'b0);
        cfg_single = 1'b0; cfg_single_b = 1'b0;
    endtask

    task automatic t_gaps();
        drive_symbol("R12 with gaps", 1'b1, 1'b0);
    endtask

    task automatic t_collide();
        cfg_scramble = 1'b1;
        for (int s = 0; s < 40 && m_step(m_lfsr)[6] != 1'b0; s++)
            drive_symbol("R7", 1'b0, 1'b0);
        chk("R9", "setup reached clear next sign", 32'(m_step(m_lfsr)[6]), 32'd0);
        drive_symbol("R7", 1'b0, 1'b1);
        drive_symbol("R9 reload over step", 1'b0, 1'b0);
        cfg_scramble = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_basic();
        t_scramble();
        t_most_negative();
        t_overlap();
        t_single();
        t_gaps();
        t_collide();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule